// File: doc/BRIEF.md
# Circular Buffer Echo Engine

This block produces a running echo of an audio input by sweeping forever over a window of sample memory. A start pulse latches a window base address and a slot count, then presets every slot in the window to mid-scale silence. After that, for each slot it sends the byte already stored there to a DAC, blends half of that byte with half of the newest converter byte, and writes the blend back into the same slot. Each pass round the window hears the previous pass at half strength, so the echo decays over time.

The converter side follows a read-to-convert handshake. Reading a result byte also launches the next conversion. One dummy read primes the converter before the first slot, and the engine holds each slot until the converter's busy flag is low. The memory port is a single synchronous port. A read returns data one clock later. A stop input is synchronized on chip and acted on only at the end of a slot.

Top module: `echo_loop_top`

## Requirements
- R1: After reset the engine is idle: `active_o`, `mem_we_o`, `mem_re_o` and `adc_rd_o` are 0 and `dac_o` is 128.
- R2: A `start_i` pulse while idle latches `base_i` and `len_i` (1 or more) and writes 128 to addresses base, base+1, …, base+len-1 on consecutive cycles, with `adc_rd_o` low. No other address is written during the fill. A memory read and a memory write are never requested in the same cycle.
- R3: After the last fill write and before any slot is processed, exactly one `adc_rd_o` pulse is given with `mem_we_o` low. This is the priming read. Every `adc_rd_o` pulse lasts exactly one cycle.
- R4: A memory read (`mem_re_o`) for a slot is issued only after a cycle in which `adc_busy_i` was low, and the read is issued in a cycle in which `adc_busy_i` is low.
- R5: `dac_o` changes only in the cycle in which a slot is written back. In that cycle it shows the byte that the slot held before the write.
- R6: The write-back of a slot is (old >> 1) + (adc >> 1), an unsigned 8-bit sum that never exceeds 254. Here adc is `adc_data_i` as held when the slot was processed. The write-back cycle also carries the one-cycle `adc_rd_o` pulse that launches the next conversion.
- R7: Write-backs visit base, base+1, …, base+len-1 and then wrap to base, indefinitely. Addresses are taken modulo 2^ADDR_W.
- R8: `stop_i` passes through a two-stage synchronizer and is examined only at the end of each slot. Once stop is seen, the engine goes idle without another write, so at most two write-backs occur after `stop_i` rises. A stop raised during the fill lets the fill, the priming read and one slot complete.
- R9: `start_i` while the engine is active is ignored. The latched window is unchanged and no fill writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| stop_i | input | 1 | Stop request, asynchronous |
| base_i | input | ADDR_W | Window base address |
| len_i | input | ADDR_W | Window slot count (1 or more) |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_data_i | input | DATA_W | Converter result byte |
| adc_rd_o | output | 1 | Result read strobe; launches a conversion |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_re_o | output | 1 | Memory read enable; data returns next cycle |
| mem_rdata_i | input | DATA_W | Memory read data |
| dac_o | output | DATA_W | Playback sample to DAC |
| active_o | output | 1 | Engine is running (fill or echo loop) |

## Verification
The assertions assume that the converter raises `adc_busy_i` in the cycle after each `adc_rd_o` pulse. They also assume that `adc_data_i` changes only when a conversion ends and that memory returns read data exactly one cycle after `mem_re_o`. The bench's converter model follows that contract, and each conversion lasts a random 2 to 6 cycles. The bench's memory model has a one-cycle read latency. Windows are random, with a slot count of at least 1. Directed runs cover a single-slot window, a window that wraps past the top of the address space, full-scale converter data, a stop raised during the fill, and a start pulse given while the engine is running.

// File: rtl/echo_pkg.sv
package echo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_PRIME,
        ST_WAIT,
        ST_READ,
        ST_MIX,
        ST_WRITE
    } echo_state_t;

    function automatic int mid_scale(input int width);
        return 1 << (width - 1);
    endfunction

endpackage

// File: rtl/echo_stop_sync.sv
module echo_stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/echo_offset_gen.sv
module echo_offset_gen #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              clr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] off_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] off_d, off_q;

    assign last_o = (off_q == len_i - 1'b1);

    always_comb begin
        off_d = off_q;
        if (clr_i)       off_d = '0;
        else if (step_i) off_d = last_o ? '0 : off_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign off_o = off_q;

    // R7: a step either advances by one or wraps to zero after the last slot
    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> (off_o == '0 || off_o == $past(off_o) + 1'b1));
    assert_wrap_at_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && last_o) |=> (off_o == '0));
endmodule

// File: rtl/echo_mixer.sv
module echo_mixer #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    output logic [DATA_W-1:0] sum_o
);
    always_comb begin
        sum_o = (old_i >> 1) + (new_i >> 1);
    end
endmodule

// File: rtl/echo_loop_top.sv
module echo_loop_top
    import echo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] dac_o,
    output logic              active_o
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(mid_scale(DATA_W));
    localparam logic [DATA_W-1:0] TOP_SUM = {DATA_W{1'b1}} - 1'b1;

    typedef struct packed {
        echo_state_t       st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
        logic              we;
        logic              re;
        logic              rd;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] dac;
    } eng_t;

    eng_t              r_d, r_q;
    logic              stop_s;
    logic              clr, step, last;
    logic [ADDR_W-1:0] off;
    logic [DATA_W-1:0] mix;

    echo_stop_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(stop_i), .sync_o(stop_s)
    );

    echo_offset_gen #(.ADDR_W(ADDR_W)) u_off (
        .clk(clk), .rst_n(rst_n), .len_i(r_q.len), .clr_i(clr),
        .step_i(step), .off_o(off), .last_o(last)
    );

    echo_mixer #(.DATA_W(DATA_W)) u_mix (
        .old_i(mem_rdata_i), .new_i(adc_data_i), .sum_o(mix)
    );

    always_comb begin
        r_d  = r_q;
        clr  = 1'b0;
        step = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_FILL;
                    r_d.base  = base_i;
                    r_d.len   = len_i;
                    r_d.we    = 1'b1;
                    r_d.wdata = MID;
                    clr       = 1'b1;
                end
            end
            ST_FILL: begin
                if (last) begin
                    r_d.we = 1'b0;
                    r_d.rd = 1'b1;
                    r_d.st = ST_PRIME;
                    clr    = 1'b1;
                end else begin
                    step = 1'b1;
                end
            end
            ST_PRIME: begin
                r_d.rd = 1'b0;
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (!adc_busy_i) begin
                    r_d.re = 1'b1;
                    r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                r_d.re = 1'b0;
                r_d.st = ST_MIX;
            end
            ST_MIX: begin
                r_d.dac   = mem_rdata_i;
                r_d.wdata = mix;
                r_d.we    = 1'b1;
                r_d.rd    = 1'b1;
                r_d.st    = ST_WRITE;
            end
            ST_WRITE: begin
                r_d.we = 1'b0;
                r_d.rd = 1'b0;
                if (stop_s) begin
                    r_d.st = ST_IDLE;
                    clr    = 1'b1;
                end else begin
                    step   = 1'b1;
                    r_d.st = ST_WAIT;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.base  <= '0;
            r_q.len   <= '0;
            r_q.we    <= 1'b0;
            r_q.re    <= 1'b0;
            r_q.rd    <= 1'b0;
            r_q.wdata <= '0;
            r_q.dac   <= MID;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = r_q.base + off;
    assign mem_we_o    = r_q.we;
    assign mem_re_o    = r_q.re;
    assign mem_wdata_o = r_q.wdata;
    assign adc_rd_o    = r_q.rd;
    assign dac_o       = r_q.dac;
    assign active_o    = (r_q.st != ST_IDLE);

    // R2: a single memory port never carries a read and a write together
    assert_no_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));
    // R3: converter read strobe is a one-cycle pulse
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd_o |=> !adc_rd_o);
    // R4: memory read follows a cycle with the converter idle
    assert_read_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |-> !$past(adc_busy_i));
    // R5: playback value moves only on a write-back
    assert_dac_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_o) |-> (mem_we_o && adc_rd_o));
    // R6: write-back blends half of old byte with half of converter byte
    assert_blend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && adc_rd_o) |->
            (mem_wdata_o == (dac_o >> 1) + ($past(adc_data_i) >> 1)));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && adc_rd_o) |-> (mem_wdata_o <= TOP_SUM));
    // R9: latched window is frozen while running
    assert_window_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |=> ($stable(r_q.base) && $stable(r_q.len)) || !active_o);
endmodule

// File: tb/tb_echo_loop_top.sv
module tb_echo_loop_top;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW-1:0] len_i = '0;
    logic          adc_busy_i;
    logic [DW-1:0] adc_data_i;
    logic          adc_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_we_o;
    logic [DW-1:0] mem_wdata_o;
    logic          mem_re_o;
    logic [DW-1:0] mem_rdata_i;
    logic [DW-1:0] dac_o;
    logic          active_o;

    echo_loop_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .base_i(base_i), .len_i(len_i), .adc_busy_i(adc_busy_i),
        .adc_data_i(adc_data_i), .adc_rd_o(adc_rd_o), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_re_o(mem_re_o),
        .mem_rdata_i(mem_rdata_i), .dac_o(dac_o), .active_o(active_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    logic [DW-1:0] mem    [DEPTH];
    logic [DW-1:0] refmem [DEPTH];

    bit            force_max = 0;
    logic [AW-1:0] base_e;
    logic [AW-1:0] len_e;
    logic [AW-1:0] off_e;
    int            fill_k;
    int            echo_cnt;
    bit            prime_seen;
    int            cnt_conv;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] blend(input logic [DW-1:0] o, input logic [DW-1:0] n);
        return (o >> 1) + (n >> 1);
    endfunction

    // converter model: busy from the cycle after a read strobe, 2..6 cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy_i <= 1'b0;
            adc_data_i <= 8'h80;
            cnt_conv   <= 0;
        end else if (adc_rd_o) begin
            adc_busy_i <= 1'b1;
            cnt_conv   <= $urandom_range(2, 6);
        end else if (adc_busy_i) begin
            if (cnt_conv <= 1) begin
                adc_busy_i <= 1'b0;
                adc_data_i <= force_max ? 8'hFF : DW'($urandom);
            end
            cnt_conv <= cnt_conv - 1;
        end
    end

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    end

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_we_o && !adc_rd_o) begin
                logic [AW-1:0] ea;
                ea = base_e + AW'(fill_k);
                chk(fill_k < int'(len_e), "R9", "fill write beyond window/after start", fill_k, int'(len_e));
                chk(mem_addr_o == ea, "R2", "fill address", mem_addr_o, ea);
                chk(mem_wdata_o == 8'd128, "R2", "fill value", mem_wdata_o, 128);
                refmem[ea] = 8'd128;
                fill_k++;
            end
            if (adc_rd_o && !mem_we_o) begin
                chk(!prime_seen && fill_k == int'(len_e), "R3", "priming read after fill, once",
                    fill_k, int'(len_e));
                prime_seen = 1;
            end
            if (mem_we_o && adc_rd_o) begin
                logic [AW-1:0] ea;
                logic [DW-1:0] old, nw;
                ea  = base_e + off_e;
                old = refmem[ea];
                nw  = blend(old, adc_data_i);
                chk(prime_seen, "R3", "slot before priming read", 0, 1);
                chk(mem_addr_o == ea, "R7", "slot address", mem_addr_o, ea);
                chk(dac_o == old, "R5", "dac shows old byte", dac_o, old);
                chk(mem_wdata_o == nw, "R6", "write-back blend", mem_wdata_o, nw);
                chk(mem_wdata_o <= 8'd254, "R6", "write-back range", mem_wdata_o, 254);
                refmem[ea] = nw;
                off_e = (off_e == len_e - 1'b1) ? '0 : off_e + 1'b1;
                echo_cnt++;
            end
            if (mem_re_o)
                chk(!adc_busy_i, "R4", "memory read while converter busy", adc_busy_i, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 20000 && active_o; i++) @(negedge clk);
    endtask

    task automatic wait_echo(input int n);
        for (int i = 0; i < 40000 && echo_cnt < n; i++) @(negedge clk);
    endtask

    task automatic run_session(input logic [AW-1:0] b, input logic [AW-1:0] l,
                               input int slots, input bit fmax, input bit early_stop);
        int n0, mism;
        @(negedge clk);
        base_e = b; len_e = l; off_e = '0;
        fill_k = 0; echo_cnt = 0; prime_seen = 0; force_max = fmax;
        base_i = b; len_i = l; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (early_stop) begin
            stop_i = 1'b1;
            wait_idle();
            stop_i = 1'b0;
            chk(fill_k == int'(l), "R8", "fill completes under stop", fill_k, int'(l));
            chk(echo_cnt == 1, "R8", "one slot after stop in fill", echo_cnt, 1);
        end else begin
            wait_echo(slots / 2);
            base_i = b + 10'd100; len_i = l + 1'b1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_echo(slots);
            chk(active_o, "R9", "still active after ignored start", active_o, 1);
            n0 = echo_cnt;
            stop_i = 1'b1;
            wait_idle();
            stop_i = 1'b0;
            chk(echo_cnt - n0 <= 2, "R8", "write-backs after stop", echo_cnt - n0, 2);
            chk(fill_k == int'(l), "R9", "fill writes in session", fill_k, int'(l));
        end
        n0 = echo_cnt;
        repeat (30) @(negedge clk);
        chk(!active_o, "R8", "idle after stop", active_o, 0);
        chk(echo_cnt == n0, "R8", "no writes while idle", echo_cnt, n0);
        mism = 0;
        for (int a = 0; a < DEPTH; a++) if (mem[a] !== refmem[a]) mism++;
        chk(mism == 0, "R2", "memory image vs expected", mism, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) begin
            mem[a]    = 8'h5A;
            refmem[a] = 8'h5A;
        end
        repeat (5) @(negedge clk);
        chk(!active_o && !mem_we_o && !mem_re_o && !adc_rd_o, "R1", "idle outputs in reset",
            {active_o, mem_we_o, mem_re_o, adc_rd_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!active_o && !mem_we_o && !mem_re_o && !adc_rd_o, "R1", "idle outputs after reset",
            {active_o, mem_we_o, mem_re_o, adc_rd_o}, 0);
        chk(dac_o == 8'd128, "R1", "dac reset value", dac_o, 128);

        run_session(10'd0, 10'd1, 6, 1'b0, 1'b0);      // single slot window
        run_session(10'd1020, 10'd8, 20, 1'b1, 1'b0);  // wraps past top, full-scale input
        run_session(10'd200, 10'd5, 0, 1'b0, 1'b1);    // stop raised during fill
        for (int s = 0; s < 6; s++) begin
            logic [AW-1:0] b, l;
            b = AW'($urandom_range(0, DEPTH - 1));
            l = AW'($urandom_range(2, 40));
            run_session(b, l, 2 * int'(l) + int'($urandom_range(1, 5)), 1'b0, 1'b0);
        end
        summary();
    end
endmodule